// File: doc/BRIEF.md
# Dual Store Queue Flush Unit

This unit sits beside a processor core and gives it two line-sized write buffers. Each buffer holds one 32-byte line. The core fills a buffer one 32-bit word at a time, and each word write carries byte enables. The core then triggers a flush by issuing a prefetch-style request whose address falls inside a reserved window. On that request the unit sends the whole selected buffer to external memory as a single eight-beat burst.

The two buffers work as a ping-pong pair. While one buffer drains, the core may keep writing the other at full speed. A write aimed at the draining buffer is stalled until its burst has ended. Only one flush is in flight at a time. The prefetch port reports not-ready while a flush is active, so a second trigger waits.

The burst destination is a 29-bit physical address aligned to 32 bytes. It is built in one of two modes:

- **Untranslated mode:** the trigger address supplies most of the bits, and a per-buffer 3-bit area field supplies the top three.
- **Translated mode:** a lookup port returns a physical page number and a page size, which are merged with the trigger address.

A lookup miss or a protection fault cancels the burst and flags an error.

Top module: `sq_flush_unit`

## Requirements
- R1: A prefetch request starts a flush only when its address bits [31:26] equal 6'b111000 (0xE000_0000 to 0xE3FF_FFFC). Any other prefetch address is consumed with no burst, no error and no change to `pfReady`.
- R2: A flush emits exactly 8 beats. Beat k carries word k of the selected buffer, for k = 0 to 7, and `memLast` is high only on beat 7. `memAddr` has bits [4:0] equal to zero and is held for the whole burst. A beat completes only when `memValid` and `memReady` are both high, and address and data stay stable while it waits.
- R3: While one buffer is being flushed, a write to the other buffer is never stalled.
- R4: A write to the buffer being flushed sees `wrStall` high from the cycle after the trigger is accepted. The write is accepted in the cycle after the last beat is taken.
- R5: In untranslated mode (`mmuOn`=0), trigger bit [5] selects the buffer (0 = buffer 0, 1 = buffer 1). The destination is {area[2:0], trig[25:5], 5'b0}, where area is `areaHi0` for buffer 0 and `areaHi1` for buffer 1. Trigger bits [4:2] have no effect.
- R6: While a flush is in progress (lookup or burst), `pfReady` is low, so at most one flush is outstanding.
- R7: In translated mode (`mmuOn`=1), the unit raises `xlReq` with `xlVaddr` equal to the trigger address and waits for `xlRspValid`. The destination is {P, trig[9:5], 5'b0}. P is formed from `xlPpn` (physical bits [28:10]) with its low n bits replaced by trig[10+n-1:10]. n is set by `xlPageSize`: 0 for 2'b00 (1 KB), 2 for 2'b01 (4 KB), 6 for 2'b10 (64 KB), 10 for 2'b11 (1 MB). The buffer is still chosen by trigger bit [5].
- R8: If a translated-mode lookup returns `xlHit`=0 or `xlFault`=1, `xlErr` pulses for one cycle, no beat is sent, and `pfReady` returns high.
- R9: Each accepted word write updates only the byte lanes whose `wrByteEn` bit is set. Lane i covers data bits [8i+7:8i].
- R10: After reset, `memValid`, `wrStall`, `xlReq` and `xlErr` are low and `pfReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mmuOn | input | 1 | 1 selects translated destination mode |
| areaHi0 | input | 3 | Physical bits [28:26] for buffer 0 in untranslated mode |
| areaHi1 | input | 3 | Physical bits [28:26] for buffer 1 in untranslated mode |
| wrValid | input | 1 | Core word write request |
| wrQueue | input | 1 | Target buffer of the write |
| wrIdx | input | 3 | Word index inside the buffer |
| wrData | input | 32 | Write data |
| wrByteEn | input | 4 | Byte lane enables |
| wrStall | output | 1 | Write held this cycle |
| pfValid | input | 1 | Prefetch request |
| pfAddr | input | 32 | Prefetch address |
| pfReady | output | 1 | Prefetch request can be taken |
| xlReq | output | 1 | Translation lookup request (level) |
| xlVaddr | output | 32 | Address to translate |
| xlRspValid | input | 1 | Lookup result valid |
| xlHit | input | 1 | Lookup found a mapping |
| xlFault | input | 1 | Lookup reports a protection fault |
| xlPpn | input | 19 | Physical page number, bits [28:10] |
| xlPageSize | input | 2 | Page size code |
| xlErr | output | 1 | One-cycle error pulse on a failed lookup |
| memValid | output | 1 | Burst beat valid |
| memAddr | output | 29 | Burst start physical address |
| memData | output | 32 | Beat data |
| memLast | output | 1 | Final beat of the burst |
| memReady | input | 1 | Memory accepts the beat |

## Verification
The bench uses the default parameters: eight 32-bit words per buffer, so each flush is a full 32-byte, eight-beat burst and the top word index 7 is reachable. With this width, every byte-lane enable pattern of a word write can be applied. Memory backpressure runs throughout, which stretches bursts and exercises both the stall window and the address hold. The top of the trigger window, all four page-size codes, and both lookup failure kinds are driven against independently computed destinations.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int PA_W      = 29;
  localparam int LINE_OFS  = 5;
  localparam int PPN_W     = PA_W - 10;
  localparam logic [5:0] SQ_WINDOW_TAG = 6'b111000;

  typedef enum logic [1:0] {ST_IDLE, ST_XLATE, ST_BURST} sq_state_e;

  typedef enum logic [1:0] {PG_1K = 2'b00, PG_4K = 2'b01, PG_64K = 2'b10, PG_1M = 2'b11} pg_size_e;

  typedef struct packed {
    logic trigLoad;
    logic useXlat;
    logic xlLoad;
    logic beatFire;
  } sq_strobe_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mmuOn,
  input  logic       pfValid,
  input  logic [5:0] pfTag,
  input  logic       wrValid,
  input  logic       wrQueue,
  input  logic       activeQ,
  input  logic       beatLast,
  input  logic       xlRspValid,
  input  logic       xlHit,
  input  logic       xlFault,
  input  logic       memReady,
  output logic       pfReady,
  output logic       wrStall,
  output logic       xlReq,
  output logic       xlErr,
  output logic       memValid,
  output sq_strobe_t strobe
);
  sq_state_e state, stateNext;
  logic      busy;
  logic      errNext;

  assign busy    = (state != ST_IDLE);
  assign pfReady = !busy;
  assign wrStall = wrValid && busy && (wrQueue == activeQ);
  assign xlReq   = (state == ST_XLATE);
  assign memValid = (state == ST_BURST);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    errNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pfValid && (pfTag == SQ_WINDOW_TAG)) begin
          strobe.trigLoad = 1'b1;
          strobe.useXlat  = mmuOn;
          stateNext       = mmuOn ? ST_XLATE : ST_BURST;
        end
      end
      ST_XLATE: begin
        if (xlRspValid) begin
          if (xlHit && !xlFault) begin
            strobe.xlLoad = 1'b1;
            stateNext     = ST_BURST;
          end else begin
            errNext   = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_BURST: begin
        if (memReady) begin
          strobe.beatFire = 1'b1;
          if (beatLast) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      xlErr <= 1'b0;
    end else begin
      state <= stateNext;
      xlErr <= errNext;
    end
  end
endmodule

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sq_strobe_t        strobe,
  input  logic [2:0]        areaHi0,
  input  logic [2:0]        areaHi1,
  input  logic [31:0]       pfAddr,
  input  logic              wrAccept,
  input  logic              wrQueue,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BYTES-1:0]  wrByteEn,
  input  logic [PPN_W-1:0]  xlPpn,
  input  logic [1:0]        xlPageSize,
  output logic              activeQ,
  output logic              beatLast,
  output logic [31:0]       xlVaddr,
  output logic [PA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memLast
);
  logic [DATA_W-1:0] qMem [2][WORDS];
  logic [31:0]       trigAddr;
  logic [PA_W-1:0]   physAddr;
  logic [IDX_W-1:0]  beatIdx;
  logic [2:0]        areaSel;

  function automatic logic [PPN_W-1:0] mergePage(logic [PPN_W-1:0] ppn,
                                                 logic [PPN_W-1:0] va,
                                                 pg_size_e sz);
    logic [PPN_W-1:0] keep;
    case (sz)
      PG_1K:   keep = '0;
      PG_4K:   keep = PPN_W'(19'h00003);
      PG_64K:  keep = PPN_W'(19'h0003F);
      default: keep = PPN_W'(19'h003FF);
    endcase
    return (ppn & ~keep) | (va & keep);
  endfunction

  // Byte-lane storage for both buffers
  for (genvar q = 0; q < 2; q++) begin : g_queue
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      for (genvar b = 0; b < BYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
          if (wrAccept && (wrQueue == 1'(q)) && (wrIdx == IDX_W'(w)) && wrByteEn[b])
            qMem[q][w][8*b +: 8] <= wrData[8*b +: 8];
        end
      end
    end
  end

  assign areaSel = pfAddr[LINE_OFS] ? areaHi1 : areaHi0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigAddr <= '0;
      physAddr <= '0;
      activeQ  <= 1'b0;
      beatIdx  <= '0;
    end else begin
      if (strobe.trigLoad) begin
        trigAddr <= pfAddr;
        activeQ  <= pfAddr[LINE_OFS];
        beatIdx  <= '0;
        if (!strobe.useXlat)
          physAddr <= {areaSel, pfAddr[25:LINE_OFS], {LINE_OFS{1'b0}}};
      end
      if (strobe.xlLoad)
        physAddr <= {mergePage(xlPpn, trigAddr[PA_W-1:10], pg_size_e'(xlPageSize)),
                     trigAddr[9:LINE_OFS], {LINE_OFS{1'b0}}};
      if (strobe.beatFire)
        beatIdx <= beatIdx + 1'b1;
    end
  end

  assign beatLast = (beatIdx == IDX_W'(WORDS - 1));
  assign memLast  = beatLast;
  assign memAddr  = physAddr;
  assign memData  = qMem[activeQ][beatIdx];
  assign xlVaddr  = trigAddr;
endmodule

// File: rtl/sq_flush_unit.sv
module sq_flush_unit
  import sq_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mmuOn,
  input  logic [2:0]        areaHi0,
  input  logic [2:0]        areaHi1,
  input  logic              wrValid,
  input  logic              wrQueue,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BYTES-1:0]  wrByteEn,
  output logic              wrStall,
  input  logic              pfValid,
  input  logic [31:0]       pfAddr,
  output logic              pfReady,
  output logic              xlReq,
  output logic [31:0]       xlVaddr,
  input  logic              xlRspValid,
  input  logic              xlHit,
  input  logic              xlFault,
  input  logic [PPN_W-1:0]  xlPpn,
  input  logic [1:0]        xlPageSize,
  output logic              xlErr,
  output logic              memValid,
  output logic [PA_W-1:0]   memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              memLast,
  input  logic              memReady
);
  sq_strobe_t strobe;
  logic       activeQ;
  logic       beatLast;

  sq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mmuOn      (mmuOn),
    .pfValid    (pfValid),
    .pfTag      (pfAddr[31:26]),
    .wrValid    (wrValid),
    .wrQueue    (wrQueue),
    .activeQ    (activeQ),
    .beatLast   (beatLast),
    .xlRspValid (xlRspValid),
    .xlHit      (xlHit),
    .xlFault    (xlFault),
    .memReady   (memReady),
    .pfReady    (pfReady),
    .wrStall    (wrStall),
    .xlReq      (xlReq),
    .xlErr      (xlErr),
    .memValid   (memValid),
    .strobe     (strobe)
  );

  sq_datapath #(.WORDS(WORDS), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .areaHi0    (areaHi0),
    .areaHi1    (areaHi1),
    .pfAddr     (pfAddr),
    .wrAccept   (wrValid && !wrStall),
    .wrQueue    (wrQueue),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .wrByteEn   (wrByteEn),
    .xlPpn      (xlPpn),
    .xlPageSize (xlPageSize),
    .activeQ    (activeQ),
    .beatLast   (beatLast),
    .xlVaddr    (xlVaddr),
    .memAddr    (memAddr),
    .memData    (memData),
    .memLast    (memLast)
  );
endmodule

// File: rtl/sq_flush_checker.sv
module sq_flush_checker
  import sq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStall,
  input logic              pfReady,
  input logic              xlReq,
  input logic              xlErr,
  input logic              memValid,
  input logic              memReady,
  input logic              memLast,
  input logic [PA_W-1:0]   memAddr,
  input logic [DATA_W-1:0] memData
);
  // R2: start address aligned to the line
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> (memAddr[LINE_OFS-1:0] == '0));

  // R2: a waiting beat keeps address and data
  a_r2_hold_beat: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData)));

  // R2: the burst ends after the last beat is taken
  a_r2_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && memLast) |=> !memValid);

  // R4 / R3: stalls only occur while a flush is active
  a_r4_stall_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    wrStall |-> (memValid || xlReq));

  // R6: no new trigger taken while a flush is active
  a_r6_single_flush: assert property (@(posedge clk) disable iff (!rstN)
    (memValid || xlReq) |-> !pfReady);

  // R8: a failed lookup sends no burst and frees the trigger port
  a_r8_err_no_burst: assert property (@(posedge clk) disable iff (!rstN)
    xlErr |-> (!memValid && pfReady));

  // R8: the error is a single-cycle pulse
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    xlErr |=> !xlErr);
endmodule

bind sq_flush_unit sq_flush_checker #(.DATA_W(DATA_W)) u_sq_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrStall  (wrStall),
  .pfReady  (pfReady),
  .xlReq    (xlReq),
  .xlErr    (xlErr),
  .memValid (memValid),
  .memReady (memReady),
  .memLast  (memLast),
  .memAddr  (memAddr),
  .memData  (memData)
);

// File: tb/test_sq_flush_unit.sv
module test_sq_flush_unit;
  import sq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS  = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              mmuOn;
  logic [2:0]        areaHi0, areaHi1;
  logic              wrValid, wrQueue;
  logic [2:0]        wrIdx;
  logic [DATA_W-1:0] wrData;
  logic [3:0]        wrByteEn;
  logic              wrStall;
  logic              pfValid;
  logic [31:0]       pfAddr;
  logic              pfReady;
  logic              xlReq;
  logic [31:0]       xlVaddr;
  logic              xlRspValid, xlHit, xlFault;
  logic [PPN_W-1:0]  xlPpn;
  logic [1:0]        xlPageSize;
  logic              xlErr;
  logic              memValid;
  logic [PA_W-1:0]   memAddr;
  logic [DATA_W-1:0] memData;
  logic              memLast;
  logic              memReady;

  sq_flush_unit #(.WORDS(WORDS), .DATA_W(DATA_W)) i_sq_flush_unit (
    .clk(clk), .rstN(rstN), .mmuOn(mmuOn), .areaHi0(areaHi0), .areaHi1(areaHi1),
    .wrValid(wrValid), .wrQueue(wrQueue), .wrIdx(wrIdx), .wrData(wrData),
    .wrByteEn(wrByteEn), .wrStall(wrStall), .pfValid(pfValid), .pfAddr(pfAddr),
    .pfReady(pfReady), .xlReq(xlReq), .xlVaddr(xlVaddr), .xlRspValid(xlRspValid),
    .xlHit(xlHit), .xlFault(xlFault), .xlPpn(xlPpn), .xlPageSize(xlPageSize),
    .xlErr(xlErr), .memValid(memValid), .memAddr(memAddr), .memData(memData),
    .memLast(memLast), .memReady(memReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [PA_W-1:0]   addr;
    logic [DATA_W-1:0] data;
    logic              last;
    string             tag;
  } beat_t;

  beat_t             expQ[$];
  logic [DATA_W-1:0] model [2][WORDS];
  int nChecks = 0;
  int nFails  = 0;
  int errSeen = 0;
  int beatNo  = 0;

  logic [PPN_W-1:0] cfgPpn;
  logic [1:0]       cfgSize;
  logic             cfgHit, cfgFault;
  logic [31:0]      lastVaddr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [PPN_W-1:0] expPage(logic [PPN_W-1:0] ppn, logic [PPN_W-1:0] va,
                                               logic [1:0] sz);
    int n;
    logic [PPN_W-1:0] m;
    case (sz)
      2'b00: n = 0;
      2'b01: n = 2;
      2'b10: n = 6;
      default: n = 10;
    endcase
    m = PPN_W'((1 << n) - 1);
    return (ppn & ~m) | (va & m);
  endfunction

  // Monitor: pop and compare each accepted beat
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (xlErr) errSeen++;
      if (memValid && memReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1", "unexpected beat", 64'(memAddr), 64'(0));
        end else begin
          beat_t b;
          b = expQ.pop_front();
          check(memAddr == b.addr, b.tag, "destination", 64'(memAddr), 64'(b.addr));
          check(memData == b.data, "R2", $sformatf("beat %0d data", beatNo), 64'(memData), 64'(b.data));
          check(memLast == b.last, "R2", "last flag", 64'(memLast), 64'(b.last));
          beatNo = b.last ? 0 : beatNo + 1;
        end
      end
    end
  end

  // Memory backpressure pattern
  initial begin
    int cyc = 0;
    memReady = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      memReady = (cyc % 4) != 3;
    end
  end

  // Translation responder
  initial begin
    xlRspValid = 1'b0; xlHit = 1'b0; xlFault = 1'b0; xlPpn = '0; xlPageSize = 2'b00;
    forever begin
      @(negedge clk);
      if (xlReq) begin
        lastVaddr = xlVaddr;
        @(negedge clk);
        @(negedge clk);
        xlHit = cfgHit; xlFault = cfgFault; xlPpn = cfgPpn; xlPageSize = cfgSize;
        xlRspValid = 1'b1;
        @(negedge clk);
        xlRspValid = 1'b0;
      end
    end
  end

  task automatic doWrite(input bit q, input int idx, input logic [31:0] d,
                         input logic [3:0] be, output int stalls);
    @(negedge clk);
    wrValid = 1'b1; wrQueue = q; wrIdx = 3'(idx); wrData = d; wrByteEn = be;
    stalls = 0;
    #1;
    while (wrStall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    for (int b = 0; b < 4; b++)
      if (be[b]) model[q][idx][8*b +: 8] = d[8*b +: 8];
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic doFlush(input logic [31:0] a, input bit expectBurst, input string tag);
    bit q;
    logic [PA_W-1:0] dst;
    @(negedge clk);
    #1;
    while (!pfReady) begin
      @(negedge clk);
      #1;
    end
    pfValid = 1'b1;
    pfAddr  = a;
    q = a[5];
    if (mmuOn)
      dst = {expPage(cfgPpn, a[28:10], cfgSize), a[9:5], 5'b0};
    else
      dst = {(q ? areaHi1 : areaHi0), a[25:5], 5'b0};
    if (expectBurst)
      for (int i = 0; i < WORDS; i++) begin
        beat_t b;
        b.addr = dst; b.data = model[q][i]; b.last = (i == WORDS-1); b.tag = tag;
        expQ.push_back(b);
      end
    @(negedge clk);
    pfValid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while ((expQ.size() != 0 || !pfReady) && t < 500) begin
      @(negedge clk);
      #1;
      t++;
    end
    check(expQ.size() == 0, "R2", "burst drained", 64'(expQ.size()), 64'(0));
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int st;
    int e0;
    rstN = 1'b0; mmuOn = 1'b0; areaHi0 = 3'b101; areaHi1 = 3'b010;
    wrValid = 1'b0; wrQueue = 1'b0; wrIdx = '0; wrData = '0; wrByteEn = '0;
    pfValid = 1'b0; pfAddr = '0;
    cfgPpn = 19'h6C3A9; cfgSize = 2'b00; cfgHit = 1'b1; cfgFault = 1'b0;
    for (int q = 0; q < 2; q++)
      for (int i = 0; i < WORDS; i++) model[q][i] = 'x;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R10: reset state
    check(memValid == 1'b0, "R10", "memValid", 64'(memValid), 64'(0));
    check(pfReady == 1'b1, "R10", "pfReady", 64'(pfReady), 64'(1));
    check(wrStall == 1'b0, "R10", "wrStall", 64'(wrStall), 64'(0));
    check(xlReq == 1'b0, "R10", "xlReq", 64'(xlReq), 64'(0));
    check(xlErr == 1'b0, "R10", "xlErr", 64'(xlErr), 64'(0));

    // Fill both buffers, then partial byte-lane writes (R9)
    for (int q = 0; q < 2; q++)
      for (int i = 0; i < WORDS; i++)
        doWrite(q[0], i, 32'h1000_0000 * (q + 1) + 32'h0101_0101 * i, 4'hF, st);
    doWrite(1'b0, 3, 32'hAABB_CCDD, 4'b0101, st);
    doWrite(1'b0, 7, 32'h1122_3344, 4'b1000, st);
    doWrite(1'b1, 0, 32'hDEAD_BEEF, 4'b0010, st);

    // R5: untranslated flush of buffer 0, trigger bits [4:2] set (ignored)
    doFlush(32'hE000_0000 | (32'h12345 << 6) | (32'h7 << 2), 1'b1, "R5");
    #1;
    check(pfReady == 1'b0, "R6", "pfReady during flush", 64'(pfReady), 64'(0));
    doWrite(1'b1, 5, 32'h5555_AAAA, 4'hF, st);
    check(st == 0, "R3", "stall cycles on other buffer", 64'(st), 64'(0));
    doWrite(1'b0, 2, 32'h7777_0000, 4'hF, st);
    check(st > 0, "R4", "stall on draining buffer", 64'(st), 64'(1));
    check(expQ.size() == 0, "R4", "write held until burst end", 64'(expQ.size()), 64'(0));
    drain();

    // R5: buffer 1 at the top of the window, R9 partial data included
    doFlush(32'hE3FF_FFFC, 1'b1, "R5");
    drain();
    doFlush(32'hE000_0020, 1'b1, "R5");
    drain();

    // R1: addresses outside the window
    doFlush(32'hE400_0000, 1'b0, "R1");
    #1;
    check(pfReady == 1'b1, "R1", "pfReady after outside address", 64'(pfReady), 64'(1));
    doFlush(32'h1234_5660, 1'b0, "R1");
    repeat (4) begin
      @(negedge clk);
      #1;
      check(memValid == 1'b0, "R1", "no burst for outside address", 64'(memValid), 64'(0));
    end

    // R7: translated mode, all page sizes
    mmuOn = 1'b1;
    for (int s = 0; s < 4; s++) begin
      cfgSize = 2'(s);
      cfgPpn  = 19'h6C3A9 ^ PPN_W'(s * 19'h1111);
      doFlush(32'hE1AB_CDE0 ^ (32'(s) << 12), 1'b1, "R7");
      drain();
      check(lastVaddr == (32'hE1AB_CDE0 ^ (32'(s) << 12)), "R7", "lookup address",
            64'(lastVaddr), 64'(32'hE1AB_CDE0 ^ (32'(s) << 12)));
    end
    cfgSize = 2'b01;
    doFlush(32'hE2F0_3C40, 1'b1, "R7");
    drain();

    // R8: lookup miss and protection fault
    e0 = errSeen;
    cfgHit = 1'b0; cfgFault = 1'b0;
    doFlush(32'hE000_1000, 1'b0, "R8");
    repeat (8) @(negedge clk);
    check(errSeen == e0 + 1, "R8", "error pulse on miss", 64'(errSeen), 64'(e0 + 1));
    cfgHit = 1'b1; cfgFault = 1'b1;
    doFlush(32'hE000_1020, 1'b0, "R8");
    repeat (8) @(negedge clk);
    #1;
    check(errSeen == e0 + 2, "R8", "error pulse on fault", 64'(errSeen), 64'(e0 + 2));
    check(pfReady == 1'b1, "R8", "pfReady after error", 64'(pfReady), 64'(1));
    check(expQ.size() == 0, "R8", "no beats after error", 64'(expQ.size()), 64'(0));

    mmuOn = 1'b0;
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule